// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block is the first decision stage for every 32-bit virtual address on its way to memory. It looks at a two-bit translation-mode field and a sixteen-bit per-segment direct-map mask, then sends the address down one of three routes. With translation switched off, the address passes through unchanged with full rights. In a directly mapped segment, the physical address is built from a 4-bit base value taken from one of two packed base registers. In all other cases the paged lookup stage decides, and this block only applies the page frame number and the miss flag that the page stage returns.

The segment number is the top nibble of the address. Segments 0 to 7 take their base nibble from the low base register and segments 8 to 15 from the high one. Instruction fetches are steered to the instruction-side page lookup; loads and stores go to the data side. The translated result is combinational. A registered strobe tells the page stage one cycle later that a paged request was presented.

Top module: `seg_xlate_front`

## Requirements
- R1: When `xlt_mode` is 2'b00, translation is off: `phys_addr` equals `vaddr`, `prot` is 3'b111, and `miss` is 0. The `prot` bits are bit 0 read, bit 1 write and bit 2 execute.
- R2: Translation is on whenever `xlt_mode` is 2'b01, 2'b10 or 2'b11.
- R3: With translation on, the segment is `vaddr[31:28]`. The access is direct-mapped when bit `seg` of `seg_direct_en` is 1, and paged otherwise.
- R4: A direct-mapped access takes its base nibble from `kbase_lo` for segments 0 to 7 and from `kbase_hi` for segments 8 to 15. The nibble sits at bits 4*(seg mod 8)+3 down to 4*(seg mod 8). `phys_addr` is {nibble, `vaddr[27:0]`}.
- R5: A direct-mapped access always has `miss` = 0 and `prot` = 3'b111, whatever the page response says.
- R6: A paged access drives `phys_addr` = {`pg_pfn`, 13'b0} and `miss` = `pg_miss`. Its `prot` is `pg_prot` on a hit and 3'b000 on a miss.
- R7: Outside the paged route, `miss` stays 0 even while `pg_miss` is 1.
- R8: `path_imem` is 1 when `acc_kind` is 2'b10 (execute). It is 0 for 2'b00 (read), 2'b01 (write) and the spare code 2'b11, which counts as a data access.
- R9: `pg_req_valid` is 1 in the cycle after a clock edge that sampled `req_valid` = 1 on the paged route. Otherwise it is 0, and it is 0 during and right after reset.
- R10: `phys_addr`, `prot`, `miss` and `path_imem` follow their inputs in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An address is presented this cycle |
| vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | 00 read, 01 write, 10 execute, 11 treated as read |
| xlt_mode | input | 2 | Translation mode field; 00 means off |
| seg_direct_en | input | 16 | Per-segment direct-map enable |
| kbase_lo | input | 32 | Packed base nibbles for segments 0-7 |
| kbase_hi | input | 32 | Packed base nibbles for segments 8-15 |
| pg_pfn | input | 19 | Page frame number from the page stage |
| pg_miss | input | 1 | Page stage found no usable entry |
| pg_prot | input | 3 | Rights granted by the page stage |
| phys_addr | output | 32 | Physical address |
| prot | output | 3 | Granted rights (read, write, execute) |
| miss | output | 1 | Translation fault from the paged route |
| path_imem | output | 1 | 1 selects the instruction-side page lookup |
| pg_req_valid | output | 1 | Registered strobe of a paged request |

## Verification
The address, rights, miss flag and path select have no register on the way. They are due in the same cycle as the stimulus, so each check drives its inputs at a falling edge and samples one time unit later, before the next rising edge. The only registered output is `pg_req_valid`, which is due one rising edge after `req_valid` is sampled. Those checks apply the request at a falling edge, wait for one rising edge and sample just after it. They then confirm that the strobe clears one edge after the request goes away or leaves the paged route.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int VA_W     = 32;
    localparam int SEG_W    = 4;
    localparam int NSEG     = 1 << SEG_W;
    localparam int PG_SHIFT = 13;
    localparam int PFN_W    = VA_W - PG_SHIFT;
    localparam int NIB_W    = 4;
    localparam int BASE_W   = 32;
    localparam int NIB_PER_REG = BASE_W / NIB_W;

    localparam logic [2:0] PROT_ALL  = 3'b111;
    localparam logic [2:0] PROT_NONE = 3'b000;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RT_BYPASS  = 2'b00,
        RT_SEGMENT = 2'b01,
        RT_PAGED   = 2'b10
    } route_e;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        logic [2:0]      prot;
        logic            miss;
    } xlt_res_t;

    function automatic logic is_exec(input acc_e k);
        return k == ACC_EX;
    endfunction

endpackage

// File: rtl/xlt_mode_dec.sv
module xlt_mode_dec
    import xlt_pkg::*;
#(
    parameter int N_SEG = NSEG,
    parameter int S_W   = SEG_W
) (
    input  logic [1:0]       mode,
    input  logic [N_SEG-1:0] direct_en,
    input  logic [S_W-1:0]   seg,
    output route_e           route
);
    always_comb begin
        if (mode == 2'b00)
            route = RT_BYPASS;
        else if (direct_en[seg])
            route = RT_SEGMENT;
        else
            route = RT_PAGED;
    end
endmodule

// File: rtl/xlt_seg_map.sv
module xlt_seg_map
    import xlt_pkg::*;
#(
    parameter int A_W   = VA_W,
    parameter int S_W   = SEG_W,
    parameter int B_W   = BASE_W,
    parameter int N_W   = NIB_W
) (
    input  logic [A_W-1:0] va,
    input  logic [B_W-1:0] base_lo,
    input  logic [B_W-1:0] base_hi,
    output logic [A_W-1:0] pa
);
    localparam int N_SEG   = 1 << S_W;
    localparam int PER_REG = B_W / N_W;
    localparam int OFF_W   = A_W - S_W;

    logic [N_W-1:0] nib_tab [N_SEG];
    logic [S_W-1:0] seg;

    assign seg = va[A_W-1 -: S_W];

    for (genvar g = 0; g < N_SEG; g++) begin : g_nib
        if (g < PER_REG) begin : g_lo
            assign nib_tab[g] = base_lo[(g % PER_REG)*N_W +: N_W];
        end else begin : g_hi
            assign nib_tab[g] = base_hi[(g % PER_REG)*N_W +: N_W];
        end
    end

    assign pa = {nib_tab[seg], va[OFF_W-1:0]};
endmodule

// File: rtl/xlt_page_req.sv
module xlt_page_req
    import xlt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  route_e route,
    output logic   pg_req_valid
);
    always_ff @(posedge clk) begin
        if (rst)
            pg_req_valid <= 1'b0;
        else
            pg_req_valid <= req_valid && (route == RT_PAGED);
    end
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
    import xlt_pkg::*;
#(
    parameter int A_W = VA_W,
    parameter int S_W = SEG_W,
    parameter int P_S = PG_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [A_W-1:0]        vaddr,
    input  logic [1:0]            acc_kind,
    input  logic [1:0]            xlt_mode,
    input  logic [(1<<S_W)-1:0]   seg_direct_en,
    input  logic [31:0]           kbase_lo,
    input  logic [31:0]           kbase_hi,
    input  logic [A_W-P_S-1:0]    pg_pfn,
    input  logic                  pg_miss,
    input  logic [2:0]            pg_prot,
    output logic [A_W-1:0]        phys_addr,
    output logic [2:0]            prot,
    output logic                  miss,
    output logic                  path_imem,
    output logic                  pg_req_valid
);
    localparam int N_SEG = 1 << S_W;

    route_e         route;
    logic [A_W-1:0] seg_pa;
    xlt_res_t       res;

    xlt_mode_dec #(.N_SEG(N_SEG), .S_W(S_W)) u_dec (
        .mode      (xlt_mode),
        .direct_en (seg_direct_en),
        .seg       (vaddr[A_W-1 -: S_W]),
        .route     (route)
    );

    xlt_seg_map #(.A_W(A_W), .S_W(S_W), .B_W(32), .N_W(NIB_W)) u_seg (
        .va      (vaddr),
        .base_lo (kbase_lo),
        .base_hi (kbase_hi),
        .pa      (seg_pa)
    );

    xlt_page_req u_preq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .route        (route),
        .pg_req_valid (pg_req_valid)
    );

    always_comb begin
        case (route)
            RT_SEGMENT: res = '{pa: seg_pa, prot: PROT_ALL, miss: 1'b0};
            RT_PAGED:   res = '{pa: {pg_pfn, {P_S{1'b0}}},
                                prot: pg_miss ? PROT_NONE : pg_prot,
                                miss: pg_miss};
            default:    res = '{pa: vaddr, prot: PROT_ALL, miss: 1'b0};
        endcase
    end

    assign phys_addr = res.pa;
    assign prot      = res.prot;
    assign miss      = res.miss;
    assign path_imem = is_exec(acc_e'(acc_kind));
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] vaddr,
    input logic [1:0]  acc_kind,
    input logic [1:0]  xlt_mode,
    input logic [15:0] seg_direct_en,
    input logic [18:0] pg_pfn,
    input logic        pg_miss,
    input logic [31:0] phys_addr,
    input logic [2:0]  prot,
    input logic        miss,
    input logic        path_imem,
    input logic        pg_req_valid
);
    logic on_seg, on_page;
    assign on_seg  = (xlt_mode != 2'b00) && seg_direct_en[vaddr[31:28]];
    assign on_page = (xlt_mode != 2'b00) && !seg_direct_en[vaddr[31:28]];

    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (rst)
        (xlt_mode == 2'b00) |-> (phys_addr == vaddr && prot == 3'b111 && !miss)); // R1
    AST_SEG_OFFSET: assert property (@(posedge clk) disable iff (rst)
        on_seg |-> (phys_addr[27:0] == vaddr[27:0])); // R4
    AST_SEG_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        on_seg |-> (!miss && prot == 3'b111)); // R5
    AST_PAGE_ADDR: assert property (@(posedge clk) disable iff (rst)
        on_page |-> (phys_addr == {pg_pfn, 13'b0} && miss == pg_miss)); // R6
    AST_MISS_PAGED_ONLY: assert property (@(posedge clk) disable iff (rst)
        miss |-> on_page); // R7
    AST_PATH_SEL: assert property (@(posedge clk) disable iff (rst)
        path_imem == (acc_kind == 2'b10)); // R8
    AST_PREQ_RISE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && on_page) |=> pg_req_valid); // R9
    AST_PREQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && on_page) |=> !pg_req_valid); // R9
endmodule

bind seg_xlate_front xlt_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .acc_kind(acc_kind), .xlt_mode(xlt_mode), .seg_direct_en(seg_direct_en),
    .pg_pfn(pg_pfn), .pg_miss(pg_miss), .phys_addr(phys_addr), .prot(prot),
    .miss(miss), .path_imem(path_imem), .pg_req_valid(pg_req_valid)
);

// File: tb/seg_xlate_front_tb.sv
module seg_xlate_front_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  acc_kind = 2'b00;
    logic [1:0]  xlt_mode = 2'b00;
    logic [15:0] seg_direct_en = '0;
    logic [31:0] kbase_lo = 32'h8765_4321;
    logic [31:0] kbase_hi = 32'hFEDC_BA9E;
    logic [18:0] pg_pfn = '0;
    logic        pg_miss = 1'b0;
    logic [2:0]  pg_prot = 3'b000;
    logic [31:0] phys_addr;
    logic [2:0]  prot;
    logic        miss;
    logic        path_imem;
    logic        pg_req_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_xlate_front u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
        .acc_kind(acc_kind), .xlt_mode(xlt_mode), .seg_direct_en(seg_direct_en),
        .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .pg_pfn(pg_pfn),
        .pg_miss(pg_miss), .pg_prot(pg_prot), .phys_addr(phys_addr),
        .prot(prot), .miss(miss), .path_imem(path_imem),
        .pg_req_valid(pg_req_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_nib(input logic [3:0] s);
        logic [31:0] src;
        src = (s < 4'd8) ? kbase_lo : kbase_hi;
        return 4'((src >> (4 * (s % 8))) & 32'hF);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R9 reset strobe", {31'b0, pg_req_valid}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_bypass();
        @(negedge clk);
        xlt_mode = 2'b00; seg_direct_en = 16'h0000; pg_miss = 1'b1;
        vaddr = 32'hC123_4567; #1;
        check("R1 bypass addr", phys_addr, 32'hC123_4567);
        check("R1 bypass prot", {29'b0, prot}, 32'h7);
        check("R1 bypass miss", {31'b0, miss}, 32'd0);
        pg_miss = 1'b0;
    endtask

    task automatic t_enable_modes();
        for (int m = 1; m < 4; m++) begin
            @(negedge clk);
            xlt_mode = 2'(m); seg_direct_en = 16'h0000;
            vaddr = 32'h2000_4000; pg_pfn = 19'h1_2345; pg_miss = 1'b0; #1;
            check("R2 mode enables paging", phys_addr, {19'h1_2345, 13'b0});
        end
    endtask

    task automatic t_segment();
        for (int s = 0; s < 16; s += 3) begin
            @(negedge clk);
            xlt_mode = 2'b01; seg_direct_en = 16'h0001 << s;
            pg_miss = 1'b1; pg_pfn = 19'h7_FFFF;
            vaddr = {4'(s), 28'hABC_DEF1}; #1;
            check("R3 R4 segment addr", phys_addr, {ref_nib(4'(s)), 28'hABC_DEF1});
            check("R5 segment prot", {29'b0, prot}, 32'h7);
            check("R7 segment miss low", {31'b0, miss}, 32'd0);
        end
        @(negedge clk);
        seg_direct_en = 16'h8000; vaddr = 32'hF000_0010; #1;
        check("R4 top segment", phys_addr, {4'hF, 28'h000_0010});
        seg_direct_en = 16'h7FFF; #1;
        check("R3 mask bit clear pages", phys_addr, {19'h7_FFFF, 13'b0});
        pg_miss = 1'b0;
    endtask

    task automatic t_paged();
        @(negedge clk);
        xlt_mode = 2'b10; seg_direct_en = 16'h0000; vaddr = 32'h5555_5555;
        pg_pfn = 19'h0_0ABC; pg_miss = 1'b0; pg_prot = 3'b011; #1;
        check("R6 hit addr", phys_addr, {19'h0_0ABC, 13'b0});
        check("R6 hit prot", {29'b0, prot}, 32'h3);
        check("R6 hit miss", {31'b0, miss}, 32'd0);
        pg_miss = 1'b1; #1;
        check("R6 miss flag", {31'b0, miss}, 32'd1);
        check("R6 miss prot", {29'b0, prot}, 32'd0);
        pg_miss = 1'b0;
    endtask

    task automatic t_path();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            acc_kind = 2'(k); #1;
            check("R8 path select", {31'b0, path_imem}, (k == 2) ? 32'd1 : 32'd0);
        end
        acc_kind = 2'b00;
    endtask

    task automatic t_strobe();
        @(negedge clk);
        xlt_mode = 2'b01; seg_direct_en = 16'h0000; vaddr = 32'h3000_0000;
        req_valid = 1'b1;
        @(posedge clk); #1;
        check("R9 strobe paged", {31'b0, pg_req_valid}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 strobe clears", {31'b0, pg_req_valid}, 32'd0);
        @(negedge clk);
        seg_direct_en = 16'h0008; req_valid = 1'b1;
        @(posedge clk); #1;
        check("R9 no strobe on segment", {31'b0, pg_req_valid}, 32'd0);
        @(negedge clk);
        xlt_mode = 2'b00; seg_direct_en = 16'h0000;
        @(posedge clk); #1;
        check("R9 no strobe on bypass", {31'b0, pg_req_valid}, 32'd0);
        req_valid = 1'b0;
    endtask

    task automatic t_comb_same_cycle();
        @(negedge clk);
        xlt_mode = 2'b11; seg_direct_en = 16'h0002; vaddr = 32'h1000_0000;
        #1;
        check("R10 same cycle seg", phys_addr, {ref_nib(4'd1), 28'h0});
        vaddr = 32'h9000_0000; pg_pfn = 19'h4_0001; #1;
        check("R10 same cycle page", phys_addr, {19'h4_0001, 13'b0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_bypass();
        t_enable_modes();
        t_segment();
        t_paged();
        t_path();
        t_strobe();
        t_comb_same_cycle();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule